// File: doc/BRIEF.md
# Unaligned Vector Stream Aligner

This block lets a load/store path move a stream of 64-bit vectors at one per clock when the stream's starting byte address is not a multiple of eight. It sits between a command source and a plain aligned 64-bit memory port that has per-byte write enables. It keeps a small set of per-stream alignment slots. Each slot holds a saved 64-bit word, the byte offset of its stream and a word pointer. Because of this state, every vector after the first needs exactly one aligned memory access.

A load stream starts with a prime command, which reads the aligned word that holds the start byte. Each later load command reads the following aligned word and joins it with the saved one to return eight consecutive stream bytes. A store stream starts with an open command, which clears the slot. Each store command writes one merged word and keeps the new vector for the next merge. A flush command writes the tail bytes that are still held and then clears the slot.

Vectors are in stream order, most significant byte first: the byte at the lowest address sits in bits 63:56. Callers keep element alignment on their own, for example 4-byte start addresses for 32-bit elements.

Top module: `ualign_stream`

## Requirements
- R1: After reset, `ld_valid` is low, and `mem_req` is low while no command is presented.
- R2: A prime (op 0) drives a read with `mem_addr` = `cmd_addr[AW-1:3]` in the same cycle, captures offset `cmd_addr[2:0]` for the slot, and produces no `ld_valid`.
- R3: A load (op 1) reads the slot's next aligned word. Exactly two clock edges after the command, `ld_valid` is high with `ld_slot` set and `ld_data` holding the eight stream bytes that follow the previous vector, the lowest address in bits 63:56. Back-to-back loads each return a vector.
- R4: With offset 0, prime and load still return the correct consecutive words.
- R5: The four slots (`cmd_slot` 0..3) keep separate offsets, pointers and saved words, so interleaved streams do not disturb one another.
- R6: An open (op 2) makes no memory access, clears the slot's saved word, sets its offset from `cmd_addr[2:0]` and sets its pointer to `cmd_addr[AW-1:3]`. A flush issued right after an open makes no memory access.
- R7: A store (op 3) writes `mem_addr` = slot pointer. Memory lane k (bits 8k+7:8k, byte address word*8+k) gets stream byte k-offset of the new vector when k >= offset, and otherwise the held byte 8-offset+k of the previous vector. On the first store after an open, `mem_be` = 8'hFF << offset; on later stores it is 8'hFF.
- R8: A flush (op 4) after at least one store with offset != 0 writes the held bytes to lanes below the offset, with `mem_be` = ~(8'hFF << offset), and then clears the slot. With offset 0, or with nothing held, a flush makes no memory access.
- R9: A store command on one slot in the same cycle as a load return on another slot gives correct results for both.
- R10: Op codes 5, 6 and 7 make no memory access and change no slot state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 prime, 1 load, 2 open, 3 store, 4 flush |
| cmd_slot | input | 2 | Alignment slot selected |
| cmd_addr | input | AW | Byte start address (prime and open only) |
| cmd_wdata | input | 64 | Store vector, lowest address in bits 63:56 |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW-3 | Aligned word address |
| mem_be | output | 8 | Byte-lane write enables |
| mem_wdata | output | 64 | Write word, lane k holds byte word*8+k |
| mem_rdata | input | 64 | Read word, returned the cycle after the read |
| ld_valid | output | 1 | Load vector valid |
| ld_slot | output | 2 | Slot of the returned vector |
| ld_data | output | 64 | Returned vector, lowest address in bits 63:56 |

## Verification
Two events can land in the same cycle. One is a load's read data coming back and updating its slot's saved word. The other is a store command on a different slot that reads and rewrites its own saved word. The store sweep triggers this on every store: each store is issued the cycle after a load on a neighbouring slot, for all eight offsets. The bench then checks every returned load vector against the initial memory pattern, and checks every byte of the store region and of both of its neighbours against the arithmetic stream values.

// File: rtl/ualign_stream.sv
module ualign_stream #(
  parameter int AW    = 16,
  parameter int NSLOT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [$clog2(NSLOT)-1:0] cmd_slot,
  input  logic [AW-1:0]            cmd_addr,
  input  logic [63:0]              cmd_wdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [AW-4:0]            mem_addr,
  output logic [7:0]               mem_be,
  output logic [63:0]              mem_wdata,
  input  logic [63:0]              mem_rdata,
  output logic                     ld_valid,
  output logic [$clog2(NSLOT)-1:0] ld_slot,
  output logic [63:0]              ld_data
);
  localparam int SW = $clog2(NSLOT);
  localparam int WA = AW - 3;
  localparam logic [2:0] OP_PRIME = 3'd0, OP_LOAD = 3'd1, OP_OPEN = 3'd2,
                         OP_STORE = 3'd3, OP_FLUSH = 3'd4;

  logic [63:0]      hold [NSLOT];
  logic [WA-1:0]    wptr [NSLOT];
  logic [2:0]       offs [NSLOT];
  logic [NSLOT-1:0] empty;
  logic             p_vld, p_ld;
  logic [SW-1:0]    p_slot;

  function automatic logic [63:0] join_ld(input logic [63:0] o, input logic [63:0] n,
                                          input logic [2:0] off);
    logic [63:0] r;
    int x;
    for (int i = 0; i < 8; i++) begin
      x = i + int'(off);
      if (x < 8) r[63-8*i -: 8] = o[8*x +: 8];
      else       r[63-8*i -: 8] = n[8*(x-8) +: 8];
    end
    return r;
  endfunction

  function automatic logic [63:0] join_st(input logic [63:0] p, input logic [63:0] d,
                                          input logic [2:0] off);
    logic [63:0] r;
    int j;
    for (int k = 0; k < 8; k++) begin
      j = k - int'(off);
      if (j >= 0) r[8*k +: 8] = d[63-8*j -: 8];
      else        r[8*k +: 8] = p[63-8*(8+j) -: 8];
    end
    return r;
  endfunction

  wire is_prime = cmd_valid && cmd_op == OP_PRIME;
  wire is_load  = cmd_valid && cmd_op == OP_LOAD;
  wire is_open  = cmd_valid && cmd_op == OP_OPEN;
  wire is_store = cmd_valid && cmd_op == OP_STORE;
  wire is_flush = cmd_valid && cmd_op == OP_FLUSH;

  wire [2:0]  c_off  = offs[cmd_slot];
  wire        c_emp  = empty[cmd_slot];
  wire        fl_wr  = is_flush && !c_emp && c_off != 3'd0;

  assign mem_req   = is_prime || is_load || is_store || fl_wr;
  assign mem_we    = is_store || fl_wr;
  assign mem_addr  = is_prime ? cmd_addr[AW-1:3] : wptr[cmd_slot];
  assign mem_be    = is_store ? (c_emp ? (8'hFF << c_off) : 8'hFF) :
                     fl_wr    ? ~(8'hFF << c_off) :
                     (is_prime || is_load) ? 8'hFF : 8'h00;
  assign mem_wdata = join_st(hold[cmd_slot], is_store ? cmd_wdata : 64'd0, c_off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_vld    <= 1'b0;
      p_ld     <= 1'b0;
      p_slot   <= '0;
      ld_valid <= 1'b0;
      ld_slot  <= '0;
      ld_data  <= '0;
      empty    <= '1;
      for (int s = 0; s < NSLOT; s++) begin
        hold[s] <= '0;
        wptr[s] <= '0;
        offs[s] <= '0;
      end
    end else begin
      p_vld    <= is_prime || is_load;
      p_ld     <= is_load;
      p_slot   <= cmd_slot;
      ld_valid <= p_vld && p_ld;
      ld_slot  <= p_slot;
      if (p_vld && p_ld) ld_data <= join_ld(hold[p_slot], mem_rdata, offs[p_slot]);
      if (is_prime) begin
        offs[cmd_slot] <= cmd_addr[2:0];
        wptr[cmd_slot] <= cmd_addr[AW-1:3] + WA'(1);
      end
      if (is_load) wptr[cmd_slot] <= wptr[cmd_slot] + WA'(1);
      if (is_open) begin
        hold[cmd_slot]  <= '0;
        offs[cmd_slot]  <= cmd_addr[2:0];
        wptr[cmd_slot]  <= cmd_addr[AW-1:3];
        empty[cmd_slot] <= 1'b1;
      end
      if (is_store) begin
        hold[cmd_slot]  <= cmd_wdata;
        wptr[cmd_slot]  <= wptr[cmd_slot] + WA'(1);
        empty[cmd_slot] <= 1'b0;
      end
      if (is_flush) begin
        hold[cmd_slot]  <= '0;
        empty[cmd_slot] <= 1'b1;
      end
      if (p_vld) hold[p_slot] <= mem_rdata;
    end
  end

  // R3
  ld_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(cmd_valid && cmd_op == OP_LOAD, 2));

  // R2
  prime_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PRIME) |-> (mem_req && !mem_we && mem_addr == cmd_addr[AW-1:3]));

  // R7
  write_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 8'h00));

  // R8
  flush_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_FLUSH) |-> !mem_be[7]);

  // R10
  idle_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op > OP_FLUSH) |-> !mem_req);

  // R6
  open_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_OPEN) |-> !mem_req);
endmodule

// File: tb/sim_ualign_stream.sv
module sim_ualign_stream;
  localparam int AW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_slot = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [63:0] cmd_wdata = '0;
  logic        mem_req, mem_we;
  logic [AW-4:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        ld_valid;
  logic [1:0]  ld_slot;
  logic [63:0] ld_data;

  int checks = 0;
  int errs = 0;

  logic [7:0]  mb [512];
  logic [63:0] exp_d [256];
  logic [1:0]  exp_s [256];
  string       exp_t [256];
  int wi = 0;
  int ri = 0;

  always #5 clk = ~clk;

  ualign_stream #(.AW(AW), .NSLOT(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_slot(cmd_slot), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
    .ld_slot(ld_slot), .ld_data(ld_data));

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int k = 0; k < 8; k++)
          if (mem_be[k]) mb[{mem_addr[5:0], 3'(k)}] <= mem_wdata[8*k +: 8];
      end else begin
        for (int k = 0; k < 8; k++)
          mem_rdata[8*k +: 8] <= mb[{mem_addr[5:0], 3'(k)}];
      end
    end
  end

  function automatic logic [7:0] pat(int a); return 8'(a * 7 + 3); endfunction
  function automatic logic [7:0] bgv(int a); return 8'(a * 5 + 90); endfunction
  function automatic logic [7:0] sdat(int n, int off); return 8'(n * 13 + off * 29 + 7); endfunction

  function automatic logic [63:0] vec_at(int a);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[63-8*i -: 8] = pat(a + i);
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ld_valid) begin
      if (ri >= wi) chk(1'b0, "R2 unexpected ld_valid", {62'd0, ld_slot}, 64'd0);
      else begin
        chk(ld_data == exp_d[ri] && ld_slot == exp_s[ri], exp_t[ri], ld_data, exp_d[ri]);
        ri++;
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [1:0] s, input int a, input logic [63:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_slot = s; cmd_addr = AW'(a); cmd_wdata = d;
    #1;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [1:0] s, input int a, input string tag);
    exp_d[wi] = vec_at(a); exp_s[wi] = s; exp_t[wi] = tag; wi++;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  endtask

  initial begin
    #2000000;
    checks++; errs++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int a = 0; a < 512; a++) mb[a] = (a < 256) ? pat(a) : bgv(a);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(ld_valid == 1'b0 && mem_req == 1'b0, "R1 reset", {62'd0, ld_valid, mem_req}, 64'd0);

    // R3 R4 R5: all offsets, two interleaved streams each
    for (int off = 0; off < 8; off++) begin
      int A, B;
      logic [1:0] sa, sb;
      A = 25 * off; B = 120 + 9 * off;
      sa = 2'(off); sb = 2'(off + 2);
      issue(3'd0, sa, A, '0);
      chk(mem_req && !mem_we && mem_addr == AW'(A >> 3), "R2 prime read", {51'd0, mem_addr}, 64'(A >> 3));
      issue(3'd0, sb, B, '0);
      for (int j = 0; j < 3; j++) begin
        issue(3'd1, sa, 0, '0);
        push(sa, A + 8 * j, off == 0 ? "R4 aligned load" : "R3 load");
        issue(3'd1, sb, 0, '0);
        push(sb, B + 8 * j, "R5 interleaved load");
      end
      idle(4);
    end

    // R10: unused op codes leave slot state alone
    issue(3'd0, 2'd0, 11, '0);
    for (int op = 5; op < 8; op++) begin
      issue(3'(op), 2'd0, 77, 64'hFFFF_FFFF_FFFF_FFFF);
      chk(mem_req == 1'b0, "R10 no access", {63'd0, mem_req}, 64'd0);
    end
    issue(3'd1, 2'd0, 0, '0);
    push(2'd0, 11, "R10 stream intact");
    idle(4);

    // R6 R7 R8 R9: store streams at all offsets, each store coinciding with a load return
    for (int off = 0; off < 8; off++) begin
      int A;
      logic [1:0] S, L;
      logic [63:0] d;
      A = 256 + 32 * off + off;
      S = 2'(off); L = 2'(off + 1);
      for (int a = 256; a < 512; a++) mb[a] = bgv(a);
      issue(3'd0, L, 40 + off, '0);
      issue(3'd2, S, A, '0);
      chk(mem_req == 1'b0, "R6 open quiet", {63'd0, mem_req}, 64'd0);
      for (int j = 0; j < 3; j++) begin
        issue(3'd1, L, 0, '0);
        push(L, 40 + off + 8 * j, "R9 load beside store");
        for (int i = 0; i < 8; i++) d[63-8*i -: 8] = sdat(8 * j + i, off);
        issue(3'd3, S, 0, d);
        chk(mem_be == (j == 0 ? (8'hFF << off) : 8'hFF), "R7 store enables", {56'd0, mem_be},
            {56'd0, (j == 0 ? (8'hFF << off) : 8'hFF)});
      end
      issue(3'd4, S, 0, '0);
      chk(mem_req == (off != 0) && (off == 0 || mem_be == ~(8'hFF << off)), "R8 flush",
          {55'd0, mem_req, mem_be}, {55'd0, off != 0, (off == 0 ? 8'h00 : ~(8'hFF << off))});
      issue(3'd4, S, 0, '0);
      chk(mem_req == 1'b0, "R8 flush clears", {63'd0, mem_req}, 64'd0);
      idle(4);
      for (int a = A - 1; a <= A + 24; a++) begin
        logic [7:0] e;
        if (a >= A && a < A + 24) e = sdat(a - A, off);
        else e = (a < 256) ? pat(a) : bgv(a);
        chk(mb[a] == e, (a >= A && a < A + 24) ? "R7 stored byte" : "R8 neighbour byte",
            {56'd0, mb[a]}, {56'd0, e});
      end
    end

    // R6: flush directly after open
    issue(3'd2, 2'd3, 301, '0);
    issue(3'd4, 2'd3, 0, '0);
    chk(mem_req == 1'b0, "R6 flush after open", {63'd0, mem_req}, 64'd0);
    idle(4);

    chk(ri == wi, "R3 all loads returned", 64'(ri), 64'(wi));
    summary();
  end
endmodule